// File: doc/BRIEF.md
# Vertical-Blanking Sideband Control Capture

Two spare user control levels travel to the display side by borrowing the top two bits of the second pixel's input word. In the DC-balanced dual-pixel mode the transmit half watches the VSYNC level, opens a capture window one clock after VSYNC falls, and re-samples the two borrowed bits on every clock while VSYNC stays low. It presents them on the control slot of the first pixel lane together with a valid flag. When VSYNC returns high the captured levels freeze and are held through active video until the next low period. In the other mode the borrowed bits are ordinary pixel data and no capture happens.

The receive half takes the recovered slot bits and their valid flag from the link side and turns them into steady levels. It loads on valid cycles and holds otherwise. The pixel word of the second lane is registered once on its way through. In DC-balanced mode the two borrowed bits are cleared in that word, because they no longer carry pixel data.

Top module: `vbctl_top`

## Requirements
- R1: Reset (synchronous, active high) clears `slot_ctl`, `slot_vld`, `rx_ctl` and `pix2_out` to zero and sets the VSYNC history to high, so a VSYNC that is already low when reset is released is treated as a fresh falling edge and is not sampled in the first cycle.
- R2: On the clock edge where VSYNC is first seen low after being high, nothing is captured: `slot_ctl` keeps its value and `slot_vld` is 0 after that edge.
- R3: On every later edge while VSYNC is low and `dcbal_en` is 1, `slot_ctl` loads the borrowed bits and `slot_vld` is 1 after that edge. The latency is one cycle.
- R4: On edges where VSYNC is high, `slot_ctl` holds its last captured value whatever the pixel input carries, and `slot_vld` is 0.
- R5: `slot_vld` is 1 exactly in the cycles after an edge that captured, and 0 in every other cycle.
- R6: With `dcbal_en` = 0 (pass-through mode) no capture takes place: `slot_ctl` holds and `slot_vld` is 0. The VSYNC history is still tracked in this mode.
- R7: `pix2_out` equals `pix2_in` one cycle later. When `dcbal_en` was 1 at that edge, bits DATA_W-1 and DATA_W-2 (27 and 26 by default) are cleared. When `dcbal_en` was 0, those bits are passed unchanged.
- R8: `rx_ctl` loads `rx_slot` on an edge with `rx_slot_vld` = 1 and holds on every other edge.
- R9: Bit mapping: `slot_ctl[0]` comes from `pix2_in[DATA_W-2]` (bit 26) and `slot_ctl[1]` comes from `pix2_in[DATA_W-1]` (bit 27).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Vertical sync level, low during the control window |
| dcbal_en | input | 1 | 1 = DC-balanced dual-pixel mode, 0 = pass-through |
| pix2_in | input | DATA_W | Second pixel input word; the top two bits carry control in DC-balanced mode |
| pix2_out | output | DATA_W | Registered second pixel word with the control bits stripped in DC-balanced mode |
| slot_ctl | output | 2 | Captured control levels for the first lane's control slot |
| slot_vld | output | 1 | Control slot carries control levels this cycle |
| rx_slot | input | 2 | Recovered control slot bits on the receive side |
| rx_slot_vld | input | 1 | Recovered slot bits are control levels this cycle |
| rx_ctl | output | 2 | Steady recovered control levels |

## Verification
A VSYNC history register stuck or initialised wrongly shows at `slot_vld` one cycle after the edge. It either flags the falling-edge cycle itself or misses the first real capture cycle, and the directed case that releases reset with VSYNC already low exposes the initial value in the first cycle. A capture enable that leaks into the high period shows as a `slot_ctl` change one cycle after a changed pixel input in active video. A wrong bit order shows as swapped levels on the first capture of an asymmetric pattern. A stale hold in the receive half shows at `rx_ctl` on the edge after a non-valid slot.

// File: rtl/vbctl_pkg.sv
package vbctl_pkg;

    localparam int unsigned CTL_W = 2;

    typedef enum logic {
        MODE_PASS  = 1'b0,
        MODE_DCBAL = 1'b1
    } link_mode_e;

    typedef struct packed {
        logic [CTL_W-1:0] lvl;
        logic             vld;
    } ctl_slot_t;

    function automatic logic window_open(input logic vs_now, input logic vs_prev,
                                         input link_mode_e mode);
        return (mode == MODE_DCBAL) && !vs_now && !vs_prev;
    endfunction

endpackage

// File: rtl/vbctl_window.sv
module vbctl_window
    import vbctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vsync,
    input  link_mode_e mode,
    output logic       sample_en
);
    logic vs_prev;

    always_ff @(posedge clk) begin
        if (rst) vs_prev <= 1'b1;
        else     vs_prev <= vsync;
    end

    assign sample_en = window_open(vsync, vs_prev, mode);

    AST_NO_SAMPLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        vsync |-> !sample_en); // R4
endmodule

// File: rtl/vbctl_sampler.sv
module vbctl_sampler
    import vbctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [CTL_W-1:0] src,
    output ctl_slot_t        slot
);
    for (genvar b = 0; b < CTL_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)            slot.lvl[b] <= 1'b0;
            else if (sample_en) slot.lvl[b] <= src[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot.vld <= 1'b0;
        else     slot.vld <= sample_en;
    end

    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(slot.lvl)); // R4
endmodule

// File: rtl/vbctl_datapath.sv
module vbctl_datapath
    import vbctl_pkg::*;
#(
    parameter int unsigned DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  link_mode_e        mode,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] pix_out
);
    localparam int unsigned CTL_LSB = DATA_W - CTL_W;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b >= CTL_LSB) begin : g_shared
            always_ff @(posedge clk) begin
                if (rst) pix_out[b] <= 1'b0;
                else     pix_out[b] <= (mode == MODE_DCBAL) ? 1'b0 : pix_in[b];
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) pix_out[b] <= 1'b0;
                else     pix_out[b] <= pix_in[b];
            end
        end
    end

    AST_CTL_STRIPPED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DCBAL) |=> (pix_out[DATA_W-1:CTL_LSB] == '0)); // R7
endmodule

// File: rtl/vbctl_rx_hold.sv
module vbctl_rx_hold
    import vbctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctl_slot_t        slot,
    output logic [CTL_W-1:0] lvl
);
    always_ff @(posedge clk) begin
        if (rst)           lvl <= '0;
        else if (slot.vld) lvl <= slot.lvl;
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot.vld |=> $stable(lvl)); // R8
endmodule

// File: rtl/vbctl_top.sv
module vbctl_top
    import vbctl_pkg::*;
#(
    parameter int unsigned DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              dcbal_en,
    input  logic [DATA_W-1:0] pix2_in,
    output logic [DATA_W-1:0] pix2_out,
    output logic [CTL_W-1:0]  slot_ctl,
    output logic              slot_vld,
    input  logic [CTL_W-1:0]  rx_slot,
    input  logic              rx_slot_vld,
    output logic [CTL_W-1:0]  rx_ctl
);
    localparam int unsigned CTL_LSB = DATA_W - CTL_W;

    link_mode_e mode;
    logic       sample_en;
    ctl_slot_t  tx_slot;
    ctl_slot_t  rx_in;

    assign mode = dcbal_en ? MODE_DCBAL : MODE_PASS;

    vbctl_window u_window (
        .clk       (clk),
        .rst       (rst),
        .vsync     (vsync),
        .mode      (mode),
        .sample_en (sample_en)
    );

    vbctl_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .src       (pix2_in[DATA_W-1:CTL_LSB]),
        .slot      (tx_slot)
    );

    vbctl_datapath #(.DATA_W(DATA_W)) u_datapath (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .pix_in  (pix2_in),
        .pix_out (pix2_out)
    );

    assign rx_in.lvl = rx_slot;
    assign rx_in.vld = rx_slot_vld;

    vbctl_rx_hold u_rx_hold (
        .clk  (clk),
        .rst  (rst),
        .slot (rx_in),
        .lvl  (rx_ctl)
    );

    assign slot_ctl = tx_slot.lvl;
    assign slot_vld = tx_slot.vld;

    AST_EDGE_SKIPPED: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync) |=> !slot_vld); // R2
    AST_VLD_DROPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        vsync |=> !slot_vld); // R5
    AST_PASS_NO_VLD: assert property (@(posedge clk) disable iff (rst)
        !dcbal_en |=> !slot_vld); // R6
    AST_VLD_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        slot_vld |-> !$past(vsync)); // R3
endmodule

// File: tb/vbctl_top_bench.sv
module vbctl_top_bench;
    localparam int DATA_W = 28;
    localparam int NROW   = 15;
    // row: [6] vsync, [5] mode, [4:3] src {bit27,bit26}, [2:1] expected slot_ctl, [0] expected slot_vld
    localparam logic [6:0] VEC [NROW] = '{
        7'b1_1_11_00_0, // R4 high, no capture
        7'b0_1_01_00_0, // R2 falling-edge cycle skipped
        7'b0_1_10_10_1, // R3 first capture
        7'b0_1_01_01_1, // R9 bit26 -> slot_ctl[0]
        7'b0_1_11_11_1, // R3 resample
        7'b1_1_00_11_0, // R4 freeze on rise
        7'b1_1_10_11_0, // R4 hold in active video
        7'b0_1_00_11_0, // R2 second falling edge
        7'b0_1_00_00_1, // R3
        7'b0_0_11_00_0, // R6 pass mode no capture
        7'b0_1_10_10_1, // R6 resumes, R5
        7'b1_1_01_10_0, // R5
        7'b0_0_11_10_0, // R6
        7'b0_0_01_10_0, // R6
        7'b1_0_00_10_0  // R6
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              vsync = 1'b1;
    logic              dcbal_en = 1'b1;
    logic [DATA_W-1:0] pix2_in = '0;
    logic [DATA_W-1:0] pix2_out;
    logic [1:0]        slot_ctl;
    logic              slot_vld;
    logic [1:0]        rx_slot = '0;
    logic              rx_slot_vld = 1'b0;
    logic [1:0]        rx_ctl;
    int                n_chk = 0;
    int                n_err = 0;
    logic              done = 1'b0;

    always #5 clk = ~clk;

    vbctl_top #(.DATA_W(DATA_W)) u_vbctl_top (
        .clk(clk), .rst(rst), .vsync(vsync), .dcbal_en(dcbal_en),
        .pix2_in(pix2_in), .pix2_out(pix2_out),
        .slot_ctl(slot_ctl), .slot_vld(slot_vld),
        .rx_slot(rx_slot), .rx_slot_vld(rx_slot_vld), .rx_ctl(rx_ctl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 slot_ctl", 32'(slot_ctl), 0);
        chk("R1 slot_vld", 32'(slot_vld), 0);
        chk("R1 rx_ctl", 32'(rx_ctl), 0);
        chk("R1 pix2_out", 32'(pix2_out), 0);
        rst = 1'b0;

        for (int i = 0; i < NROW; i++) begin
            vsync    = VEC[i][6];
            dcbal_en = VEC[i][5];
            pix2_in  = {VEC[i][4:3], 26'h0};
            @(negedge clk);
            chk($sformatf("R3/R4 row %0d slot_ctl", i), 32'(slot_ctl), 32'(VEC[i][2:1]));
            chk($sformatf("R5 row %0d slot_vld", i), 32'(slot_vld), 32'(VEC[i][0]));
        end

        // R7 data path
        dcbal_en = 1'b1; vsync = 1'b1; pix2_in = 28'hFFFFFFF;
        @(negedge clk);
        chk("R7 dcbal strip", 32'(pix2_out), 32'h3FFFFFF);
        dcbal_en = 1'b0; pix2_in = 28'hA5A5A5A;
        @(negedge clk);
        chk("R7 pass", 32'(pix2_out), 32'hA5A5A5A);
        dcbal_en = 1'b1; pix2_in = 28'hC123456;
        @(negedge clk);
        chk("R7 dcbal strip 2", 32'(pix2_out), 32'h0123456);

        // R8 receive hold
        rx_slot = 2'b10; rx_slot_vld = 1'b1;
        @(negedge clk);
        chk("R8 load", 32'(rx_ctl), 2);
        rx_slot = 2'b01; rx_slot_vld = 1'b0;
        @(negedge clk);
        chk("R8 hold", 32'(rx_ctl), 2);
        rx_slot_vld = 1'b1;
        @(negedge clk);
        chk("R8 reload", 32'(rx_ctl), 1);
        rx_slot_vld = 1'b0;

        // R1 reset clears, then release with vsync already low
        rst = 1'b1; vsync = 1'b0; dcbal_en = 1'b1; pix2_in = {2'b11, 26'h0};
        @(negedge clk);
        chk("R1 reset slot_ctl", 32'(slot_ctl), 0);
        chk("R1 reset rx_ctl", 32'(rx_ctl), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 history high slot_ctl", 32'(slot_ctl), 0);
        chk("R1 history high slot_vld", 32'(slot_vld), 0);
        @(negedge clk);
        chk("R3 after reset slot_ctl", 32'(slot_ctl), 3);
        chk("R3 after reset slot_vld", 32'(slot_vld), 1);
        pix2_in = {2'b10, 26'h3FFFFFF};
        @(negedge clk);
        chk("R9 bit27 -> slot_ctl[1]", 32'(slot_ctl), 2);

        finish_run();
    end
endmodule